// File: doc/BRIEF.md
# Two-Wire Serial Target Bus Engine

This block is the bus-facing engine of a passive two-wire serial target. It never starts a transfer. It follows an external host: it watches the clock and data lines, recognises START, repeated START and STOP, and compares the 7-bit address the host sends with a programmed address. On a match it acknowledges. Bytes the host writes are pushed into a receive FIFO. When the host reads, bytes are popped from a transmit FIFO and shifted out. The engine talks to both FIFOs through simple push and pop strobes. Both FIFOs sit outside the block.

Both bus lines pass through a two-stage synchroniser. They are then sampled once per filter tick, and a tick comes every 8 system clocks, or every 64 when `slow_filter` is high. Every edge decision is made on these filtered samples. Short glitches between ticks are therefore never seen. Each line output is open-drain in style: it either pulls the line low or releases it. The clock line is always released, because the engine never stretches the clock. A low `enable` clears the engine at once and so abandons any transfer.

The state machine has seven states:
- IDLE: waiting for START.
- ADDR: shifting in 7 address bits and the direction bit.
- ADDR_ACK: driving the address acknowledge.
- WR_DATA: receiving a byte.
- WR_ACK: driving the data acknowledge.
- RD_DATA: shifting a byte out.
- RD_ACK: sampling the host's acknowledge.

The transitions are:
- IDLE→ADDR on START.
- ADDR→ADDR_ACK on the falling SCL that follows the 8th bit, when the address matches. ADDR→IDLE at the same point when it does not match.
- ADDR_ACK→WR_DATA or ADDR_ACK→RD_DATA on the next falling SCL, chosen by the direction bit.
- WR_DATA→WR_ACK after 8 bits, and WR_ACK→WR_DATA on the next falling SCL.
- RD_DATA→RD_ACK after 8 bits.
- RD_ACK→RD_DATA if the host acknowledged, and RD_ACK→IDLE if it did not.
- From any state: START goes to ADDR, STOP goes to IDLE, and a low `enable` goes to IDLE.

Top module: `i2c_target_engine`

## Requirements
- R1: After reset, `busy` is 0, `sda_out` is 1 (released) and `scl_out` is 1.
- R2: The lines are synchronised and sampled once per tick. A tick comes every 8 clocks, or every 64 when `slow_filter` is 1. A START is therefore reflected on `busy` within tick period + 4 clocks, and never more slowly than that.
- R3: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high, both judged on filtered samples. `busy` is high from START until STOP.
- R4: After START, 7 address bits are taken MSB-first, followed by a direction bit (0 = write, 1 = read). On a match with `dev_addr`, SDA is pulled low during the 9th SCL pulse.
- R5: On an address mismatch, the engine gives no acknowledge, drops `busy`, and ignores all bytes until the next START.
- R6: In a write transfer, each byte is received MSB-first, acknowledged on its 9th pulse, and pushed via `rx_push`/`rx_data`.
- R7: A write byte that completes while `rx_full` is 1 is still acknowledged, but it is not pushed.
- R8: In a read transfer, bytes from `tx_data` are sent MSB-first. `tx_pop` pulses once when the host acknowledges on the 9th SCL rising edge.
- R9: While `tx_empty` is 1, a read byte is sent as 0xFF and no pop happens.
- R10: On a host NACK, the engine does not pop, releases SDA and returns to IDLE. The next read phase therefore offers the same byte.
- R11: A repeated START at any point, including in the middle of a byte, returns the engine to the address phase. `busy` stays high.
- R12: Driving `enable` low returns the engine to IDLE and releases SDA within 2 clocks, even while it is driving an acknowledge.
- R13: `scl_out` is always 1. `sda_out` only starts pulling low while SCL is sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Engine enable; low clears the engine and aborts any transfer |
| slow_filter | input | 1 | 0: sample every 8 clocks, 1: sample every 64 clocks |
| dev_addr | input | 7 | Programmed target address |
| scl_in | input | 1 | Sensed SCL line level |
| sda_in | input | 1 | Sensed SDA line level |
| scl_out | output | 1 | SCL drive, 0 pulls low, 1 releases |
| sda_out | output | 1 | SDA drive, 0 pulls low, 1 releases |
| rx_push | output | 1 | One-cycle push strobe to the receive FIFO |
| rx_data | output | 8 | Received byte, valid with rx_push |
| rx_full | input | 1 | Receive FIFO full |
| tx_pop | output | 1 | One-cycle pop strobe to the transmit FIFO |
| tx_data | input | 8 | Head byte of the transmit FIFO |
| tx_empty | input | 1 | Transmit FIFO empty |
| busy | output | 1 | A transaction is in progress |

## Verification
The state machine keeps no history beyond the current byte. A wrong state or bit count therefore shows up on the bus within one byte time:
- A missing or misplaced acknowledge shows as a bad ACK bit.
- A shifted byte shows as a corrupt value on `rx_data` or on the read bits.
- A wrong pop decision shows as a wrong value in the next read phase.

Filter timing faults show on `busy` at the first START, as a latency outside the tick bound. The bench sweeps every single-bit mismatch of the address, the byte values that stress the shift path, each acknowledge outcome and each place a transfer can be cut off. It also sweeps the START phase across the tick period at both sample rates.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_DATA,
        ST_WR_ACK,
        ST_RD_DATA,
        ST_RD_ACK
    } tgt_state_t;
endpackage

// File: rtl/i2c_tgt_sampler.sv
module i2c_tgt_sampler #(
    parameter int FAST_DIV = 8,
    parameter int SLOW_DIV = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic slow,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    localparam int CW = $clog2(SLOW_DIV);

    logic [CW-1:0] div_cnt;
    logic [CW-1:0] div_lim;
    logic [1:0]    scl_sy, sda_sy;
    logic          scl_c, scl_p, sda_c, sda_p;
    logic          tick, evt_ok;

    assign div_lim = slow ? CW'(SLOW_DIV - 1) : CW'(FAST_DIV - 1);
    assign tick    = (div_cnt >= div_lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
            scl_sy  <= 2'b11;
            sda_sy  <= 2'b11;
            scl_c   <= 1'b1;
            scl_p   <= 1'b1;
            sda_c   <= 1'b1;
            sda_p   <= 1'b1;
            evt_ok  <= 1'b0;
        end else if (!enable) begin
            div_cnt <= '0;
            scl_sy  <= 2'b11;
            sda_sy  <= 2'b11;
            scl_c   <= 1'b1;
            scl_p   <= 1'b1;
            sda_c   <= 1'b1;
            sda_p   <= 1'b1;
            evt_ok  <= 1'b0;
        end else begin
            scl_sy  <= {scl_sy[0], scl_in};
            sda_sy  <= {sda_sy[0], sda_in};
            div_cnt <= tick ? '0 : div_cnt + 1'b1;
            evt_ok  <= tick;
            if (tick) begin
                scl_c <= scl_sy[1];
                scl_p <= scl_c;
                sda_c <= sda_sy[1];
                sda_p <= sda_c;
            end
        end
    end

    assign scl_lvl  = scl_c;
    assign sda_lvl  = sda_c;
    assign scl_rise = evt_ok & ~scl_p & scl_c;
    assign scl_fall = evt_ok & scl_p & ~scl_c;
    assign start_ev = evt_ok & scl_p & scl_c & sda_p & ~sda_c;
    assign stop_ev  = evt_ok & scl_p & scl_c & ~sda_p & sda_c;

    // R2: bus events only come out in the cycle after a sample tick
    a_r2_event_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_rise | scl_fall | start_ev | stop_ev) |-> $past(tick));
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic              scl_lvl,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_ev,
    input  logic              stop_ev,
    input  logic              rx_full,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_empty,
    output logic              sda_low,
    output logic              rx_push,
    output logic [BYTE_W-1:0] rx_data,
    output logic              tx_pop,
    output logic              busy
);
    tgt_state_t        state_q, state_d;
    logic [CNT_W-1:0]  bit_q;
    logic [BYTE_W-1:0] sh_q;
    logic              drive_q, push_q, pop_q, acked_q;
    logic              addr_hit, byte_done;

    assign addr_hit  = (sh_q[BYTE_W-1:1] == dev_addr);
    assign byte_done = scl_fall && (bit_q == CNT_W'(BYTE_W));

    function automatic logic [BYTE_W-1:0] pick_tx(input logic empty, input logic [BYTE_W-1:0] d);
        return empty ? '1 : d;
    endfunction

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     state_d = ST_IDLE;
            ST_ADDR:     if (byte_done) state_d = addr_hit ? ST_ADDR_ACK : ST_IDLE;
            ST_ADDR_ACK: if (scl_fall) state_d = sh_q[0] ? ST_RD_DATA : ST_WR_DATA;
            ST_WR_DATA:  if (byte_done) state_d = ST_WR_ACK;
            ST_WR_ACK:   if (scl_fall) state_d = ST_WR_DATA;
            ST_RD_DATA:  if (byte_done) state_d = ST_RD_ACK;
            ST_RD_ACK:   if (scl_fall) state_d = acked_q ? ST_RD_DATA : ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
        if (start_ev)     state_d = ST_ADDR;
        else if (stop_ev) state_d = ST_IDLE;
        if (!enable)      state_d = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q <= '0; sh_q <= '0; drive_q <= 1'b0;
            push_q <= 1'b0; pop_q <= 1'b0; acked_q <= 1'b0;
        end else if (!enable) begin
            bit_q <= '0; sh_q <= '0; drive_q <= 1'b0;
            push_q <= 1'b0; pop_q <= 1'b0; acked_q <= 1'b0;
        end else begin
            push_q <= 1'b0;
            pop_q  <= 1'b0;
            if (start_ev) begin
                bit_q   <= '0;
                drive_q <= 1'b0;
            end else if (stop_ev) begin
                drive_q <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_ADDR, ST_WR_DATA: begin
                        if (scl_rise) begin
                            sh_q  <= {sh_q[BYTE_W-2:0], sda_lvl};
                            bit_q <= bit_q + 1'b1;
                        end
                        if (byte_done) begin
                            drive_q <= (state_q == ST_ADDR) ? addr_hit : 1'b1;
                            push_q  <= (state_q == ST_WR_DATA) && !rx_full;
                        end
                    end
                    ST_ADDR_ACK: if (scl_fall) begin
                        bit_q <= '0;
                        if (sh_q[0]) begin
                            sh_q    <= pick_tx(tx_empty, tx_data);
                            drive_q <= ~pick_tx(tx_empty, tx_data)[BYTE_W-1];
                        end else begin
                            drive_q <= 1'b0;
                        end
                    end
                    ST_WR_ACK: if (scl_fall) begin
                        bit_q   <= '0;
                        drive_q <= 1'b0;
                    end
                    ST_RD_DATA: begin
                        if (scl_rise) bit_q <= bit_q + 1'b1;
                        if (byte_done) begin
                            drive_q <= 1'b0;
                        end else if (scl_fall) begin
                            sh_q    <= {sh_q[BYTE_W-2:0], 1'b1};
                            drive_q <= ~sh_q[BYTE_W-2];
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) begin
                            acked_q <= ~sda_lvl;
                            pop_q   <= ~sda_lvl & ~tx_empty;
                        end
                        if (scl_fall && acked_q) begin
                            bit_q   <= '0;
                            sh_q    <= pick_tx(tx_empty, tx_data);
                            drive_q <= ~pick_tx(tx_empty, tx_data)[BYTE_W-1];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_low = drive_q;
    assign rx_push = push_q;
    assign rx_data = sh_q;
    assign tx_pop  = pop_q;
    assign busy    = (state_q != ST_IDLE);

    // R3: a STOP always ends the transaction
    a_r3_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_ev && !start_ev) |=> !busy);
    // R11: a START or repeated START always lands in the address phase
    a_r11_start_to_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (start_ev && enable) |=> state_q == ST_ADDR);
    // R12: disable clears the engine
    a_r12_disable_idles: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!busy && !sda_low));
    // R5: a mismatching address returns to idle
    a_r5_mismatch_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !start_ev && !stop_ev && state_q == ST_ADDR && byte_done && !addr_hit) |=> !busy);
    // R7: nothing is pushed into a full receive FIFO
    a_r7_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> !$past(rx_full));
    // R9: nothing is popped from an empty transmit FIFO
    a_r9_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> !$past(tx_empty));
    // R8: pops only follow an SCL rise in the host-acknowledge slot
    a_r8_pop_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> ($past(state_q) == ST_RD_ACK && $past(scl_rise)));
    // R13: SDA is only pulled low while SCL is sampled low
    a_r13_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_q) |-> !$past(scl_lvl));
endmodule

// File: rtl/i2c_target_engine.sv
module i2c_target_engine
    import i2c_tgt_pkg::*;
#(
    parameter int FAST_DIV = 8,
    parameter int SLOW_DIV = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              slow_filter,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_out,
    output logic              sda_out,
    output logic              rx_push,
    output logic [BYTE_W-1:0] rx_data,
    input  logic              rx_full,
    output logic              tx_pop,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_empty,
    output logic              busy
);
    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev, sda_low;

    i2c_tgt_sampler #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .slow     (slow_filter),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    i2c_tgt_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .dev_addr (dev_addr),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .rx_full  (rx_full),
        .tx_data  (tx_data),
        .tx_empty (tx_empty),
        .sda_low  (sda_low),
        .rx_push  (rx_push),
        .rx_data  (rx_data),
        .tx_pop   (tx_pop),
        .busy     (busy)
    );

    assign scl_out = 1'b1;
    assign sda_out = ~sda_low;
endmodule

// File: tb/i2c_target_engine_bench.sv
module i2c_target_engine_bench;
    localparam int CLK_PERIOD = 10;
    localparam int FAST = 8;
    localparam int SLOW = 64;
    localparam logic [6:0] MY_ADDR = 7'h5A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic slow_filter = 1'b0;
    logic h_scl = 1'b1, h_sda = 1'b1;
    logic rx_full = 1'b0;
    logic scl_out, sda_out, rx_push, tx_pop, busy;
    logic [7:0] rx_data, tx_data;
    logic tx_empty;
    wire scl_line = h_scl & scl_out;
    wire sda_line = h_sda & sda_out;

    logic [7:0] tx_mem [16];
    int tx_wr = 0;
    int pop_cnt = 0;
    logic [7:0] rx_log [64];
    int rx_n = 0;
    int scl_bad = 0;
    int checks = 0, errors = 0;
    int q = 32;
    bit done = 0;

    assign tx_empty = (pop_cnt == tx_wr);
    assign tx_data  = tx_mem[pop_cnt % 16];

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_target_engine u_i2c_target_engine (
        .clk(clk), .rst_n(rst_n), .enable(enable), .slow_filter(slow_filter),
        .dev_addr(MY_ADDR), .scl_in(scl_line), .sda_in(sda_line),
        .scl_out(scl_out), .sda_out(sda_out), .rx_push(rx_push), .rx_data(rx_data),
        .rx_full(rx_full), .tx_pop(tx_pop), .tx_data(tx_data), .tx_empty(tx_empty),
        .busy(busy)
    );

    always @(posedge clk) begin
        if (rx_push) begin
            rx_log[rx_n % 64] <= rx_data;
            rx_n <= rx_n + 1;
        end
        if (tx_pop) pop_cnt <= pop_cnt + 1;
    end

    always @(negedge clk) if (rst_n && scl_out !== 1'b1) scl_bad++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        h_sda = 1'b1; wclk(q);
        h_scl = 1'b1; wclk(q);
        h_sda = 1'b0; wclk(q);
        h_scl = 1'b0; wclk(q);
    endtask

    task automatic bus_stop();
        h_sda = 1'b0; wclk(q);
        h_scl = 1'b1; wclk(q);
        h_sda = 1'b1; wclk(q);
    endtask

    task automatic clock_bit(input logic b, output logic s);
        h_sda = b;    wclk(q);
        h_scl = 1'b1; wclk(q);
        s = sda_line; wclk(q);
        h_scl = 1'b0; wclk(q);
    endtask

    task automatic send_byte(input logic [7:0] v, output bit ack);
        logic s;
        for (int i = 7; i >= 0; i--) clock_bit(v[i], s);
        clock_bit(1'b1, s);
        ack = !s;
    endtask

    task automatic recv_byte(input bit ack, output logic [7:0] v);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, s);
            v[i] = s;
        end
        clock_bit(!ack, s);
    endtask

    task automatic start_latency(input int extra, output int lat);
        int w;
        wclk(extra);
        h_sda = 1'b0;
        lat = 0;
        while (!busy && lat < 300) begin wclk(1); lat++; end
        wclk(q);
        h_sda = 1'b1;
        w = 0;
        while (busy && w < 300) begin wclk(1); w++; end
        wclk(4);
    endtask

    initial begin
        bit ack;
        logic [7:0] v;
        logic s;
        int lat, mx, base, pbase;
        logic [7:0] pats [8];
        pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5; pats[3] = 8'h5A;
        pats[4] = 8'h01; pats[5] = 8'h80; pats[6] = 8'h3C; pats[7] = 8'hC3;
        for (int i = 0; i < 16; i++) tx_mem[i] = 8'h00;

        wclk(5);
        check(busy == 1'b0, "R1 busy in reset", busy, 0);
        rst_n = 1'b1;
        wclk(3);
        check(busy == 1'b0 && sda_out == 1'b1 && scl_out == 1'b1, "R1 idle outputs",
              {busy, sda_out, scl_out}, 3'b011);
        enable = 1'b1;
        wclk(200);

        // R2/R3: START latency sweep across the tick phase, fast rate
        mx = 0;
        for (int k = 0; k < FAST; k++) begin
            start_latency(k + 20, lat);
            check(lat <= FAST + 4, "R2 fast START latency", lat, FAST + 4);
            check(busy == 1'b0, "R3 STOP clears busy", busy, 0);
        end
        // slow rate: phase swept in steps of 8 over one 64-clock period
        slow_filter = 1'b1;
        q = 256;
        wclk(300);
        for (int k = 0; k < 8; k++) begin
            start_latency(100 + 8 * k, lat);
            check(lat <= SLOW + 4, "R2 slow START latency bound", lat, SLOW + 4);
            if (lat > mx) mx = lat;
        end
        check(mx > FAST + 4, "R2 slow filter samples less often", mx, FAST + 5);
        slow_filter = 1'b0;
        q = 32;
        wclk(200);

        // R4/R6: write transfer with a sweep of byte patterns
        base = rx_n;
        bus_start();
        check(busy == 1'b1, "R3 busy after START", busy, 1);
        send_byte({MY_ADDR, 1'b0}, ack);
        check(ack == 1'b1, "R4 address ack on match", ack, 1);
        for (int i = 0; i < 8; i++) begin
            send_byte(pats[i], ack);
            check(ack == 1'b1, "R6 data byte acked", ack, 1);
        end
        bus_stop();
        wclk(4);
        check(busy == 1'b0, "R3 busy low after STOP", busy, 0);
        check(rx_n - base == 8, "R6 push count", rx_n - base, 8);
        for (int i = 0; i < 8; i++)
            check(rx_log[(base + i) % 64] == pats[i], "R6 received byte", rx_log[(base + i) % 64], pats[i]);

        // R7: full receive FIFO
        rx_full = 1'b1;
        base = rx_n;
        bus_start();
        send_byte({MY_ADDR, 1'b0}, ack);
        send_byte(8'h77, ack);
        check(ack == 1'b1, "R7 ack while full", ack, 1);
        send_byte(8'h88, ack);
        bus_stop();
        check(rx_n == base, "R7 no push while full", rx_n - base, 0);
        rx_full = 1'b0;

        // R5: every single-bit address mismatch, both directions
        for (int b = 0; b < 7; b++) begin
            base = rx_n;
            bus_start();
            send_byte({MY_ADDR ^ 7'(1 << b), b[0]}, ack);
            check(ack == 1'b0, "R5 no ack on mismatch", ack, 0);
            check(busy == 1'b0, "R5 idle after mismatch", busy, 1'b0);
            send_byte(8'h00, ack);
            check(ack == 1'b0, "R5 data ignored after mismatch", ack, 0);
            bus_stop();
            check(rx_n == base, "R5 no push after mismatch", rx_n - base, 0);
        end

        // R8/R9/R10: read transfers
        tx_mem[0] = 8'h96; tx_mem[1] = 8'h3C; tx_mem[2] = 8'h01;
        tx_wr = 3;
        pbase = pop_cnt;
        bus_start();
        send_byte({MY_ADDR, 1'b1}, ack);
        check(ack == 1'b1, "R4 read address ack", ack, 1);
        recv_byte(1'b1, v);
        check(v == 8'h96, "R8 first read byte", v, 8'h96);
        recv_byte(1'b1, v);
        check(v == 8'h3C, "R8 second read byte", v, 8'h3C);
        check(pop_cnt - pbase == 2, "R8 pops on ack", pop_cnt - pbase, 2);
        recv_byte(1'b0, v);
        check(v == 8'h01, "R8 third read byte", v, 8'h01);
        check(pop_cnt - pbase == 2, "R10 no pop on NACK", pop_cnt - pbase, 2);
        check(busy == 1'b0 && sda_out == 1'b1, "R10 released after NACK", {busy, sda_out}, 2'b01);
        bus_stop();
        bus_start();
        send_byte({MY_ADDR, 1'b1}, ack);
        recv_byte(1'b1, v);
        check(v == 8'h01, "R10 same byte offered again", v, 8'h01);
        check(pop_cnt - pbase == 3, "R8 pop after ack", pop_cnt - pbase, 3);
        recv_byte(1'b1, v);
        check(v == 8'hFF, "R9 empty sends 0xFF", v, 8'hFF);
        check(pop_cnt - pbase == 3, "R9 no pop when empty", pop_cnt - pbase, 3);
        recv_byte(1'b0, v);
        check(v == 8'hFF, "R9 empty again 0xFF", v, 8'hFF);
        bus_stop();

        // R11: repeated START after a byte, and in the middle of a byte
        base = rx_n;
        bus_start();
        send_byte({MY_ADDR, 1'b0}, ack);
        send_byte(8'h11, ack);
        bus_start();
        check(busy == 1'b1, "R11 busy across repeated START", busy, 1);
        send_byte({MY_ADDR, 1'b1}, ack);
        check(ack == 1'b1, "R11 address phase after repeated START", ack, 1);
        recv_byte(1'b0, v);
        check(v == 8'hFF, "R11 read after repeated START", v, 8'hFF);
        bus_stop();
        bus_start();
        send_byte({MY_ADDR, 1'b0}, ack);
        clock_bit(1'b0, s); clock_bit(1'b1, s); clock_bit(1'b0, s);
        bus_start();
        send_byte({MY_ADDR, 1'b0}, ack);
        check(ack == 1'b1, "R11 mid-byte repeated START re-addresses", ack, 1);
        send_byte(8'h22, ack);
        bus_stop();
        check(rx_n - base == 2, "R11 push count", rx_n - base, 2);
        check(rx_log[base % 64] == 8'h11, "R11 byte before restart", rx_log[base % 64], 8'h11);
        check(rx_log[(base + 1) % 64] == 8'h22, "R11 byte after restart", rx_log[(base + 1) % 64], 8'h22);

        // R12: disable while the engine drives an acknowledge
        bus_start();
        for (int i = 7; i >= 1; i--) clock_bit(MY_ADDR[i-1], s);
        clock_bit(1'b0, s);
        h_sda = 1'b1;
        wclk(q);
        check(sda_out == 1'b0, "R4 ack driven before abort", sda_out, 0);
        enable = 1'b0;
        wclk(2);
        check(sda_out == 1'b1 && busy == 1'b0, "R12 abort releases and idles", {busy, sda_out}, 2'b01);
        enable = 1'b1;
        wclk(20);
        bus_stop();
        wclk(20);
        check(busy == 1'b0, "R12 idle after re-enable", busy, 0);

        check(scl_bad == 0, "R13 scl_out always released", scl_bad, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule